// File: doc/BRIEF.md
# Parallel ADC Burst Capture Controller

This block sits on the host side of an 8-bit analog-to-digital converter that uses a parallel bus. The converter has an active-low chip select, separate active-low read and write strobes, and an active-low conversion-complete interrupt. When the host sends a capture request, the controller runs a burst of conversions. For each one it pulses chip select together with write, which starts the converter. It then waits for the interrupt to fall. Next it pulses chip select together with read and takes the result byte off the data bus. It writes that byte into an external sample buffer, and each byte goes to the address after the previous one.

When the programmed number of samples has been stored, the controller pulses a done flag. A burst holds sixteen samples by default. An abort input throws away a conversion that has been started but not yet finished. The controller starts that conversion again, and the abandoned conversion does not count as a sample.

Each strobe lasts one clock. An optional wait state stretches every strobe to two clocks so that a slow or heavily loaded bus has time to settle. A watchdog on the interrupt wait can end a stalled burst and raise an error flag.

Top module: `adc_burst_ctrl`

## Requirements
- R1: After reset, the three bus strobes are high (inactive), and buf_we_o, busy_o, done_o and err_o are all low.
- R2: A start_i pulse while idle begins a burst. Chip select and write go low together for L clocks, then both go high. L is 1, or 2 when cfg_wait_i was high at the start of the burst.
- R3: After a write pulse ends, the controller does nothing until it sees a falling edge on the interrupt, after two synchroniser flops. It then drives chip select and read low for exactly L clocks. Read and write are never low together, and neither is ever low while chip select is high.
- R4: The data bus is sampled on the last clock of the read pulse. On the next clock, buf_we_o is high for one cycle, buf_wdata_o carries the byte, and buf_addr_o carries the sample's position in the burst: 0 for the first sample, then counting up by one for each stored sample.
- R5: The sample count is taken from cfg_count_i when the burst starts, and values above MAX_SAMPLES are limited to MAX_SAMPLES. The burst makes exactly that many buffer writes. It then holds done_o high for one cycle, and busy_o goes low on the following cycle.
- R6: If abort_i is high while a conversion is being started or awaited, the controller issues a fresh write pulse. No byte is stored and the sample count does not advance. If abort_i is high during a read pulse, it has no effect.
- R7: Suppose cfg_timeout_i is non-zero and the interrupt does not fall within cfg_timeout_i clocks of waiting. Then err_o goes high, done_o pulses in the same cycle, and the burst ends. err_o stays high until the next start. A value of 0 turns the timeout off.
- R8: While idle, interrupt activity causes no strobe and no buffer write.
- R9: A start with a sample count of 0 raises done_o on the next clock. No strobe is driven and no byte is written.
- R10: start_i is ignored while a burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture request pulse |
| abort_i | input | 1 | Restart the conversion currently pending |
| cfg_count_i | input | CNT_W | Samples per burst |
| cfg_wait_i | input | 1 | Stretch every strobe by one clock |
| cfg_timeout_i | input | TO_W | Interrupt wait limit in clocks, 0 = off |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_wr_n_o | output | 1 | Converter start strobe, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| adc_intr_n_i | input | 1 | Converter conversion-complete interrupt, active low, asynchronous |
| adc_data_i | input | DATA_W | Converter data bus |
| buf_we_o | output | 1 | Buffer write enable |
| buf_addr_o | output | ADDR_W | Buffer write address |
| buf_wdata_o | output | DATA_W | Buffer write data |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle burst end pulse |
| err_o | output | 1 | Sticky interrupt timeout flag |

## Verification
The bound checker runs on every cycle. It checks that read and write are never low together, that no strobe is ever low while chip select is high, and that a read pulse never lasts more than two clocks. It also checks that each buffer write comes right after a read clock, that the write addresses follow a per-burst count, that an error only appears together with done, and that the bus stays quiet while the controller is idle.

Other behaviours can only be shown by the bench's scenarios, which run a behavioural converter against the design. These are:
- restarting a conversion after an abort, and ignoring an abort during a read;
- limiting the sample count to MAX_SAMPLES;
- a burst of zero samples;
- the timeout, and the error flag clearing on the next start;
- ignoring a second request while a burst runs;
- the exact order of the stored values.

// File: rtl/adc_burst_pkg.sv
package adc_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_WAIT,
        ST_RD,
        ST_DONE
    } burst_st_e;

endpackage

// File: rtl/adc_intr_sync.sv
module adc_intr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic intr_n_i,
    output logic fell_o
);
    // Synchroniser flops, followed by one extra flop for edge detection.
    logic [STAGES:0] sh_q;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh_q[g] <= 1'b1;
                    else        sh_q[g] <= intr_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh_q[g] <= 1'b1;
                    else        sh_q[g] <= sh_q[g-1];
                end
            end
        end
    endgenerate

    assign fell_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = en_i ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = en_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/adc_burst_ctrl.sv
module adc_burst_ctrl
    import adc_burst_pkg::*;
#(
    parameter int  MAX_SAMPLES = 16,
    parameter int  DATA_W      = 8,
    parameter int  TO_W        = 16,
    parameter int  SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(MAX_SAMPLES + 1),
    localparam int ADDR_W      = $clog2(MAX_SAMPLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [CNT_W-1:0]  cfg_count_i,
    input  logic              cfg_wait_i,
    input  logic [TO_W-1:0]   cfg_timeout_i,
    output logic              adc_cs_n_o,
    output logic              adc_wr_n_o,
    output logic              adc_rd_n_o,
    input  logic              adc_intr_n_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              buf_we_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    output logic [DATA_W-1:0] buf_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_SAMPLES);

    typedef struct packed {
        burst_st_e         st;
        logic              ph;
        logic              wait_en;
        logic [CNT_W-1:0]  tgt;
        logic [CNT_W-1:0]  cnt;
        logic              cs_n;
        logic              wr_n;
        logic              rd_n;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic              err;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, ph: 1'b0, wait_en: 1'b0, tgt: '0, cnt: '0,
        cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, we: 1'b0,
        addr: '0, wdata: '0, done: 1'b0, err: 1'b0
    };

    regs_t r_d, r_q;
    logic  intr_fell;
    logic  wait_expired;
    logic  ph_last;

    adc_intr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .intr_n_i (adc_intr_n_i),
        .fell_o   (intr_fell)
    );

    adc_wait_timer #(.W(TO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (r_q.st == ST_WAIT),
        .limit_i   (cfg_timeout_i),
        .expired_o (wait_expired)
    );

    // The current strobe clock is the final one of its pulse.
    assign ph_last = (r_q.ph == r_q.wait_en);

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.err     = 1'b0;
                    r_d.wait_en = cfg_wait_i;
                    r_d.tgt     = (cfg_count_i > MAX_CNT) ? MAX_CNT : cfg_count_i;
                    r_d.cnt     = '0;
                    r_d.ph      = 1'b0;
                    if (cfg_count_i == '0) begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = ST_WR;
                        r_d.cs_n = 1'b0;
                        r_d.wr_n = 1'b0;
                    end
                end
            end
            ST_WR: begin
                if (abort_i) begin
                    r_d.ph = 1'b0;
                end else if (ph_last) begin
                    r_d.cs_n = 1'b1;
                    r_d.wr_n = 1'b1;
                    r_d.st   = ST_WAIT;
                end else begin
                    r_d.ph = 1'b1;
                end
            end
            ST_WAIT: begin
                if (abort_i) begin
                    r_d.st   = ST_WR;
                    r_d.cs_n = 1'b0;
                    r_d.wr_n = 1'b0;
                    r_d.ph   = 1'b0;
                end else if (intr_fell) begin
                    r_d.st   = ST_RD;
                    r_d.cs_n = 1'b0;
                    r_d.rd_n = 1'b0;
                    r_d.ph   = 1'b0;
                end else if (wait_expired) begin
                    r_d.err  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_DONE;
                end
            end
            ST_RD: begin
                if (ph_last) begin
                    r_d.rd_n  = 1'b1;
                    r_d.we    = 1'b1;
                    r_d.wdata = adc_data_i;
                    r_d.addr  = r_q.cnt[ADDR_W-1:0];
                    r_d.cnt   = r_q.cnt + 1'b1;
                    r_d.ph    = 1'b0;
                    if (r_q.cnt + 1'b1 == r_q.tgt) begin
                        r_d.cs_n = 1'b1;
                        r_d.done = 1'b1;
                        r_d.st   = ST_DONE;
                    end else begin
                        r_d.wr_n = 1'b0;
                        r_d.st   = ST_WR;
                    end
                end else begin
                    r_d.ph = 1'b1;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign adc_cs_n_o  = r_q.cs_n;
    assign adc_wr_n_o  = r_q.wr_n;
    assign adc_rd_n_o  = r_q.rd_n;
    assign buf_we_o    = r_q.we;
    assign buf_addr_o  = r_q.addr;
    assign buf_wdata_o = r_q.wdata;
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
endmodule

// File: rtl/adc_burst_ctrl_chk.sv
module adc_burst_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_cs_n_o,
    input logic              adc_wr_n_o,
    input logic              adc_rd_n_o,
    input logic              buf_we_o,
    input logic [ADDR_W-1:0] buf_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o
);
    logic [1:0]        rd_run_q;
    logic [ADDR_W-1:0] exp_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_run_q   <= '0;
            exp_addr_q <= '0;
        end else begin
            rd_run_q   <= adc_rd_n_o ? 2'd0 : ((rd_run_q == 2'd3) ? 2'd3 : rd_run_q + 2'd1);
            exp_addr_q <= !busy_o ? '0 : (buf_we_o ? exp_addr_q + 1'b1 : exp_addr_q);
        end
    end

    assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (adc_cs_n_o && adc_wr_n_o && adc_rd_n_o && !buf_we_o));

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_rd_n_o && !adc_wr_n_o));

    assert_strobe_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_rd_n_o || !adc_wr_n_o) |-> !adc_cs_n_o);

    assert_rd_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n_o |-> (rd_run_q < 2'd2));

    assert_we_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> $past(!adc_rd_n_o));

    assert_addr_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> (buf_addr_o == exp_addr_q));

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);
endmodule

bind adc_burst_ctrl adc_burst_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_cs_n_o (adc_cs_n_o),
    .adc_wr_n_o (adc_wr_n_o),
    .adc_rd_n_o (adc_rd_n_o),
    .buf_we_o   (buf_we_o),
    .buf_addr_o (buf_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/adc_burst_ctrl_test.sv
module adc_burst_ctrl_test;
    localparam int MAXS  = 16;
    localparam int CW    = 5;
    localparam int AW    = 4;
    localparam int TW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          abort_i = 1'b0;
    logic [CW-1:0] cfg_count_i = '0;
    logic          cfg_wait_i = 1'b0;
    logic [TW-1:0] cfg_timeout_i = '0;
    logic          adc_cs_n, adc_wr_n, adc_rd_n;
    logic          adc_intr_n;
    logic [7:0]    adc_data;
    logic          buf_we;
    logic [AW-1:0] buf_addr;
    logic [7:0]    buf_wdata;
    logic          busy, done, err;

    always #10 clk = ~clk;

    // Behavioural converter
    int         conv_time = 6;
    bit         conv_en = 1'b1;
    logic       glitch_n = 1'b1;
    logic       m_intr_n = 1'b1;
    logic       m_busy = 1'b0;
    int         m_left = 0;
    logic [7:0] m_latch = 8'h00;
    logic [7:0] m_next = 8'h11;
    logic       m_prev_wr = 1'b1, m_prev_cs = 1'b1;
    int         m_starts = 0;
    logic [7:0] exp_q[$];

    assign adc_intr_n = m_intr_n & glitch_n;
    assign adc_data   = m_latch;

    always @(posedge clk) begin
        m_prev_wr <= adc_wr_n;
        m_prev_cs <= adc_cs_n;
        if (!adc_cs_n && !adc_rd_n) m_intr_n <= 1'b1;
        if (!conv_en || (!adc_cs_n && !adc_wr_n)) begin
            m_busy <= 1'b0;
        end else if (!m_prev_wr && !m_prev_cs && adc_wr_n) begin
            m_busy   <= 1'b1;
            m_left   <= conv_time;
            m_intr_n <= 1'b1;
            m_starts <= m_starts + 1;
        end else if (m_busy) begin
            if (m_left <= 1) begin
                m_busy   <= 1'b0;
                m_latch  <= m_next;
                m_intr_n <= 1'b0;
                exp_q.push_back(m_next);
                m_next   <= m_next + 8'd37;
            end else begin
                m_left <= m_left - 1;
            end
        end
    end

    adc_burst_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .cfg_count_i(cfg_count_i), .cfg_wait_i(cfg_wait_i), .cfg_timeout_i(cfg_timeout_i),
        .adc_cs_n_o(adc_cs_n), .adc_wr_n_o(adc_wr_n), .adc_rd_n_o(adc_rd_n),
        .adc_intr_n_i(adc_intr_n), .adc_data_i(adc_data),
        .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_wdata_o(buf_wdata),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-clock reference comparison
    int exp_addr = 0;
    int writes   = 0;
    int dones    = 0;
    int strobes  = 0;
    int exp_len  = 1;
    int rd_run   = 0;
    int wr_run   = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we) begin
                chk(buf_addr == AW'(exp_addr), "R4 address", int'(buf_addr), exp_addr);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected write", int'(buf_wdata), -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(buf_wdata == e, "R4 data", int'(buf_wdata), int'(e));
                end
                exp_addr++;
                writes++;
            end
            if (done) dones++;
            if (!adc_cs_n || !adc_rd_n || !adc_wr_n) strobes++;
            if (!adc_rd_n) rd_run++;
            else if (rd_run > 0) begin
                chk(rd_run == exp_len, "R3 read width", rd_run, exp_len);
                rd_run = 0;
            end
            if (!adc_wr_n) wr_run++;
            else if (wr_run > 0) begin
                chk(wr_run == exp_len, "R2 write width", wr_run, exp_len);
                wr_run = 0;
            end
        end
    end

    task automatic begin_burst(input int cnt, input bit ws, input int to);
        @(negedge clk);
        cfg_count_i   = CW'(cnt);
        cfg_wait_i    = ws;
        cfg_timeout_i = TW'(to);
        exp_len       = ws ? 2 : 1;
        exp_addr      = 0;
        writes        = 0;
        dones         = 0;
        start_i       = 1'b1;
        @(negedge clk);
        start_i       = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            if (dones > 0) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1 strobes idle", {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
        chk(!buf_we && !busy && !done && !err, "R1 flags low", {buf_we, busy, done, err}, 0);

        // R2 R3 R4 R5: full burst, no wait state
        begin_burst(16, 1'b0, 0);
        wait_done();
        chk(writes == 16, "R5 burst of 16", writes, 16);
        chk(dones == 1, "R5 single done", dones, 1);
        chk(!busy && !err, "R5 idle after done", {busy, err}, 0);
        chk(exp_q.size() == 0, "R4 all samples stored", exp_q.size(), 0);

        // R2 R3: wait state, short burst, slower converter
        conv_time = 10;
        begin_burst(5, 1'b1, 0);
        wait_done();
        chk(writes == 5, "R2 burst of 5 with wait", writes, 5);

        // R5: count above the maximum is limited
        conv_time = 4;
        begin_burst(20, 1'b0, 0);
        wait_done();
        chk(writes == MAXS, "R5 count clamp", writes, MAXS);

        // R6: abort while waiting restarts the conversion
        conv_time = 40;
        s0 = m_starts;
        begin_burst(4, 1'b0, 0);
        while (adc_wr_n) @(negedge clk);
        while (!adc_wr_n) @(negedge clk);
        repeat (4) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        wait_done();
        chk(writes == 4, "R6 abort keeps sample count", writes, 4);
        chk(m_starts - s0 == 5, "R6 extra start after abort", m_starts - s0, 5);
        chk(exp_q.size() == 0, "R6 no stale sample", exp_q.size(), 0);

        // R6: abort during a read has no effect
        conv_time = 6;
        s0 = m_starts;
        begin_burst(3, 1'b0, 0);
        while (adc_rd_n) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        wait_done();
        chk(writes == 3, "R6 abort in read ignored", writes, 3);
        chk(m_starts - s0 == 3, "R6 no restart from read abort", m_starts - s0, 3);

        // R7: timeout sets the error and ends the burst
        conv_en = 1'b0;
        begin_burst(4, 1'b0, 30);
        wait_done();
        chk(err == 1'b1, "R7 timeout error", err, 1);
        chk(writes == 0, "R7 no writes on timeout", writes, 0);
        chk(!busy, "R7 idle after timeout", busy, 0);
        conv_en = 1'b1;
        begin_burst(2, 1'b0, 200);
        @(negedge clk);
        chk(err == 1'b0, "R7 error cleared by start", err, 0);
        wait_done();
        chk(writes == 2 && !err, "R7 normal burst after error", writes, 2);

        // R8: interrupt activity while idle
        strobes = 0;
        writes  = 0;
        glitch_n = 1'b0;
        repeat (3) @(negedge clk);
        glitch_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(strobes == 0 && writes == 0, "R8 idle interrupt ignored", strobes + writes, 0);
        chk(!busy, "R8 still idle", busy, 0);

        // R9: zero-sample burst
        strobes = 0;
        begin_burst(0, 1'b0, 0);
        chk(done == 1'b1, "R9 immediate done", done, 1);
        repeat (3) @(negedge clk);
        chk(strobes == 0 && writes == 0, "R9 no bus activity", strobes + writes, 0);

        // R10: second request during a burst
        begin_burst(4, 1'b0, 0);
        repeat (20) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        repeat (40) @(negedge clk);
        chk(writes == 4, "R10 restart ignored writes", writes, 4);
        chk(dones == 1 && !busy, "R10 single done", dones, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule